// File: doc/BRIEF.md
# I2S master transmitter with programmable channel depth

This block drives a stereo I2S link as the clock master. An external two-phase tick sets the pace: every pair of ticks forms one bit period. The first tick of the pair pulls the bit clock low and presents the next data bit. The second tick raises the bit clock while data and word select hold steady. So the tick rate must be twice the bit clock, and the bit clock is the sample rate times the channel depth times two.

Sample data arrives as 32-bit words on a valid/ready stream. The block keeps a 32-bit shift register and sends it MSB first. It fetches a new word on its own each time the previous word's 32 bits have all left the register. Word boundaries are therefore independent of channel boundaries. At a depth of 16, one word carries a full stereo frame, with the left sample in the upper half. At a depth of 32, each word carries one channel. A per-channel loop counter, preset to the depth minus two, sets how many bits each channel gets. Word select changes state one bit before the channel it announces. If the source has no word ready when one is needed, the block sends zeros, raises a sticky underrun flag and keeps both clocks running.

The channel depth is taken from its input only while the block is disabled. Disabling the block also returns the link to an idle state and clears the underrun flag.

Top module: `i2s_tx_master`

## Requirements
- R1: While `rst_n` is low, `sck`, `ws`, `sd`, `in_ready` and `underrun` are all 0.
- R2: One clock after `enable` is seen low, `sck`, `ws`, `sd`, `in_ready` and `underrun` are 0. The first tick after enable opens a low half.
- R3: Each channel lasts exactly the effective depth in bits. The left channel comes first, then the channels alternate.
- R4: `ws` is 0 for every left bit except the last left bit, where it is 1. It is 1 for every right bit except the last right bit, where it is 0.
- R5: Bits leave MSB first (bit 31 of each accepted word first). Each word supplies exactly 32 consecutive bits, whatever the depth.
- R6: Ticks alternate between a low half and a high half. On a low-half tick, `sck` goes to 0 and the next `sd`/`ws` values appear one clock later. On a high-half tick, `sck` goes to 1 and `sd`/`ws` hold. Outputs change only after tick cycles.
- R7: `in_ready` is 1 only in the clock of a low-half tick whose bit number since enable is a multiple of 32. The word is taken in that clock if `in_valid` is 1.
- R8: If `in_valid` is 0 at a fetch point, 32 zero bits are sent instead. `underrun` becomes 1 and stays 1 until the block is disabled, and both clocks keep running.
- R9: Changes on `depth` while `enable` is high have no effect on the running frame.
- R10: A `depth` below 8 acts as 8, and a `depth` above 32 acts as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the link; low returns it to idle |
| tick | input | 1 | Half-bit pacing strobe, twice the bit clock rate |
| depth | input | 6 | Bits per channel, sampled while disabled |
| in_data | input | 32 | Sample word, MSB sent first |
| in_valid | input | 1 | A sample word is offered |
| in_ready | output | 1 | The word is taken in this clock |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select, 0 for left |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky missing-word flag |

## Verification
The assertions assume the tick is a plain strobe. They do not require any tick spacing, and back-to-back ticks are legal. They assume the depth register only ever holds a clamped value, because it is loaded while the block is disabled. The stimulus inserts zero to two idle clocks between ticks at random, so both continuous and sparse ticks occur. It changes `depth` while enabled only in the one run where that change must be ignored. The valid line toggles at random outside fetch points, so the bench can show that offers made there are not consumed.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
   // channel carried by the current bit; left is announced by ws = 0
   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   // which half of a bit period the next tick opens
   typedef enum logic {
      HALF_LOW  = 1'b0,
      HALF_HIGH = 1'b1
   } half_e;
endpackage

// File: rtl/i2s_tx_phase.sv
module i2s_tx_phase
   import i2s_tx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick,
   output logic emit_lo,
   output logic emit_hi,
   output logic sck
);
   half_e half_q;
   logic  sck_q;

   assign emit_lo = enable && tick && (half_q == HALF_LOW);
   assign emit_hi = enable && tick && (half_q == HALF_HIGH);
   assign sck     = sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= HALF_LOW;
         sck_q  <= 1'b0;
      end else if (!enable) begin
         half_q <= HALF_LOW;
         sck_q  <= 1'b0;
      end else if (emit_lo) begin
         half_q <= HALF_HIGH;
         sck_q  <= 1'b0;
      end else if (emit_hi) begin
         half_q <= HALF_LOW;
         sck_q  <= 1'b1;
      end
   end

   // R6
   sck_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_q != $past(sck_q)) |-> ($past(tick) || !$past(enable)));

   // R6
   lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      emit_lo |=> (half_q == HALF_HIGH) || !enable);
endmodule

// File: rtl/i2s_tx_frame.sv
module i2s_tx_frame
   import i2s_tx_pkg::*;
#(
   parameter  int WORD_W = 32,
   localparam int DW     = $clog2(WORD_W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          emit_lo,
   input  logic [DW-1:0] depth_load,
   input  logic [DW-1:0] depth_q,
   output logic          ws
);
   chan_e         ch_q;
   logic [DW-1:0] loop_q;
   logic          fin_q;
   logic          ws_q;

   assign ws = ws_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_q   <= CH_LEFT;
         loop_q <= '0;
         fin_q  <= 1'b0;
         ws_q   <= 1'b0;
      end else if (!enable) begin
         ch_q   <= CH_LEFT;
         loop_q <= DW'(depth_load - DW'(2));
         fin_q  <= 1'b0;
         ws_q   <= 1'b0;
      end else if (emit_lo) begin
         if (fin_q) begin
            // final bit of the channel: announce the next one
            ws_q   <= ~ch_q;
            ch_q   <= (ch_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
            fin_q  <= 1'b0;
            loop_q <= DW'(depth_q - DW'(2));
         end else begin
            ws_q <= ch_q;
            if (loop_q == '0) begin
               fin_q <= 1'b1;
            end else begin
               loop_q <= loop_q - DW'(1);
            end
         end
      end
   end

   // R3
   chan_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && emit_lo && fin_q) |=> (ch_q != $past(ch_q)));

   // R3
   loop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |-> (loop_q <= DW'(depth_q - DW'(2))));

   // R4
   ws_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !emit_lo) |=> $stable(ws_q) || !$past(enable));
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer #(
   parameter  int WORD_W = 32,
   localparam int LW     = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              emit_lo,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              sd,
   output logic              underrun
);
   logic [WORD_W-1:0] shreg_q;
   logic [WORD_W-1:0] word_now;
   logic [LW-1:0]     left_q;
   logic              need_word;
   logic              sd_q;
   logic              under_q;

   assign need_word = (left_q == '0);
   assign in_ready  = emit_lo && need_word;
   assign sd        = sd_q;
   assign underrun  = under_q;

   always_comb begin
      word_now = in_valid ? in_data : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         left_q  <= '0;
         sd_q    <= 1'b0;
         under_q <= 1'b0;
      end else if (!enable) begin
         shreg_q <= '0;
         left_q  <= '0;
         sd_q    <= 1'b0;
         under_q <= 1'b0;
      end else if (emit_lo) begin
         if (need_word) begin
            sd_q    <= word_now[WORD_W-1];
            shreg_q <= {word_now[WORD_W-2:0], 1'b0};
            left_q  <= LW'(WORD_W - 1);
            if (!in_valid) begin
               under_q <= 1'b1;
            end
         end else begin
            sd_q    <= shreg_q[WORD_W-1];
            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
            left_q  <= left_q - LW'(1);
         end
      end
   end

   // R7
   fetch_refills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid) |=> (left_q == LW'(WORD_W - 1)));

   // R7
   ready_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> enable);

   // R8
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (under_q && enable) |=> under_q);

   // R8
   starve_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> under_q);
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master #(
   parameter  int WORD_W    = 32,
   parameter  int MIN_DEPTH = 8,
   localparam int DW        = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic [DW-1:0]     depth,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              sck,
   output logic              ws,
   output logic              sd,
   output logic              underrun
);
   generate
      if (MIN_DEPTH < 2) begin : g_min_too_small
         $error("MIN_DEPTH must be at least 2");
      end
      if (MIN_DEPTH > WORD_W) begin : g_min_too_large
         $error("MIN_DEPTH must not exceed WORD_W");
      end
      if (WORD_W < 2) begin : g_word_too_small
         $error("WORD_W must be at least 2");
      end
   endgenerate

   logic [DW-1:0] depth_clamped;
   logic [DW-1:0] depth_q;
   logic          emit_lo;
   logic          emit_hi;

   always_comb begin
      if (depth < DW'(MIN_DEPTH)) begin
         depth_clamped = DW'(MIN_DEPTH);
      end else if (depth > DW'(WORD_W)) begin
         depth_clamped = DW'(WORD_W);
      end else begin
         depth_clamped = depth;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= DW'(MIN_DEPTH);
      end else if (!enable) begin
         depth_q <= depth_clamped;
      end
   end

   i2s_tx_phase u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .tick    (tick),
      .emit_lo (emit_lo),
      .emit_hi (emit_hi),
      .sck     (sck)
   );

   i2s_tx_frame #(.WORD_W(WORD_W)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .emit_lo    (emit_lo),
      .depth_load (depth_clamped),
      .depth_q    (depth_q),
      .ws         (ws)
   );

   i2s_tx_serializer #(.WORD_W(WORD_W)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .emit_lo  (emit_lo),
      .in_data  (in_data),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .sd       (sd),
      .underrun (underrun)
   );

   // R9
   depth_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |-> $stable(depth_q));

   // R10
   depth_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_q >= DW'(MIN_DEPTH)) && (depth_q <= DW'(WORD_W)));

   // R6
   half_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(emit_lo && emit_hi));
endmodule

// File: tb/i2s_tx_master_tb.sv
module i2s_tx_master_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        enable;
   logic        tick;
   logic [5:0]  depth;
   logic [31:0] in_data;
   logic        in_valid;
   logic        in_ready;
   logic        sck;
   logic        ws;
   logic        sd;
   logic        underrun;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   i2s_tx_master u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .tick     (tick),
      .depth    (depth),
      .in_data  (in_data),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .sck      (sck),
      .ws       (ws),
      .sd       (sd),
      .underrun (underrun)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_ws(input int k, input int eff);
      int j = k % eff;
      int c = (k / eff) % 2;
      return (j == eff - 1) ? logic'(c == 0) : logic'(c == 1);
   endfunction

   task automatic check_idle(input string tag);
      check({tag, " sck"}, 32'(sck), 0);
      check({tag, " ws"}, 32'(ws), 0);
      check({tag, " sd"}, 32'(sd), 0);
      check({tag, " in_ready"}, 32'(in_ready), 0);
      check({tag, " underrun"}, 32'(underrun), 0);
   endtask

   // idle clocks between ticks: outputs must hold (R6), no fetch (R7)
   task automatic gap(input logic sd_e, input logic ws_e, input logic sck_e);
      int g = int'($urandom % 3);
      if (g > 0) begin
         tick = 1'b0;
         for (int i = 0; i < g; i++) begin
            in_valid = 1'($urandom % 2);
            #1 check("R7 ready idle", 32'(in_ready), 0);
            @(negedge clk);
            check("R6 sck hold", 32'(sck), 32'(sck_e));
            check("R6 sd hold", 32'(sd), 32'(sd_e));
            check("R6 ws hold", 32'(ws), 32'(ws_e));
         end
      end
   endtask

   task automatic run_stream(input logic [5:0] dset, input int eff, input int nbits,
                             input int vpct, input bit chg);
      logic [31:0] cur = '0;
      bit          exp_ur = 1'b0;
      logic        sd_e;
      logic        ws_e;
      enable   = 1'b0;
      tick     = 1'b0;
      in_valid = 1'b0;
      depth    = dset;
      repeat (2) @(negedge clk);
      check_idle("R2 before run");
      enable = 1'b1;
      for (int k = 0; k < nbits; k++) begin
         bit          fetch = ((k % 32) == 0);
         bit          v;
         logic [31:0] d = $urandom;
         if (fetch) begin
            v = (int'($urandom % 100) < vpct);
            if (vpct < 100 && k == 32) v = 1'b0;
         end else begin
            v = 1'($urandom % 2);
         end
         in_valid = v;
         in_data  = d;
         tick     = 1'b1;
         #1 check("R7 ready at low half", 32'(in_ready), 32'(fetch));
         if (fetch) begin
            cur = v ? d : 32'h0;
            if (!v) exp_ur = 1'b1;
         end
         @(negedge clk);
         sd_e = cur[31 - (k % 32)];
         ws_e = exp_ws(k, eff);
         check("R6 sck low", 32'(sck), 0);
         check("R5 sd bit", 32'(sd), 32'(sd_e));
         check("R3 R4 ws", 32'(ws), 32'(ws_e));
         check("R8 underrun", 32'(underrun), 32'(exp_ur));
         gap(sd_e, ws_e, 1'b0);
         tick     = 1'b1;
         in_valid = 1'($urandom % 2);
         #1 check("R7 ready at high half", 32'(in_ready), 0);
         @(negedge clk);
         check("R6 sck high", 32'(sck), 1);
         check("R6 sd held", 32'(sd), 32'(sd_e));
         check("R6 ws held", 32'(ws), 32'(ws_e));
         gap(sd_e, ws_e, 1'b1);
         // R9: a new depth while running must not alter the frame
         if (chg && k == nbits / 2) depth = dset ^ 6'h0C;
      end
      tick     = 1'b0;
      in_valid = 1'b0;
      enable   = 1'b0;
      @(negedge clk);
      check_idle("R2 after disable");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      rst_n    = 1'b0;
      enable   = 1'b0;
      tick     = 1'b0;
      depth    = 6'd16;
      in_data  = '0;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check_idle("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);

      run_stream(6'd16, 16, 128, 100, 1'b0);
      run_stream(6'd32, 32, 96, 100, 1'b0);
      run_stream(6'd24, 24, 144, 100, 1'b0);
      run_stream(6'd8, 8, 96, 100, 1'b0);
      // R10 clamping on both sides
      run_stream(6'd5, 8, 64, 100, 1'b0);
      run_stream(6'd40, 32, 96, 100, 1'b0);
      // R8 starvation with R9 depth change mid-run
      run_stream(6'd16, 16, 192, 70, 1'b1);
      for (int r = 0; r < 3; r++) begin
         int dd = 8 + int'($urandom % 25);
         run_stream(6'(dd), dd, 100, 90, 1'b0);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule